// File: doc/BRIEF.md
# Stride-detecting cache line prefetcher

This block sits beside a data cache and watches the stream of demand misses. It learns a stride from the set indices of consecutive misses, as a signed number of lines. Once a run of equally spaced misses reaches a run length chosen at run time, it issues line-fill requests for the lines that follow along the same stride. These requests continue in the background with no further misses needed. They stop once a fixed number of lines have been issued, or once the next line would leave the 4 KB page of the miss that started the burst.

Requests leave on a valid/ready channel that carries line addresses, meaning the physical address with the 6 offset bits dropped. A miss that breaks the run starts a new candidate stride from the last two misses. A repeated set index never counts as a stride. Dropping the enable input clears both the training state and any burst in progress. A run that completes while a burst is still active is not queued.

Top module: `stride_prefetch`

## Requirements
- R1: A miss address is split into a line offset (bits 5:0), a set index (bits 12:6) and a tag (upper bits). The line address is bits 31:6 and the 4 KB page is bits 31:12. The offset bits have no effect on any request.
- R2: A burst starts when the k-th consecutive miss with the same nonzero set-index stride is captured. The stride is the difference of successive set indices taken modulo 128, as a signed value from -64 to 63. k is run_len, and values below 2 act as 2. pf_valid first rises in the cycle after the clock edge that captures that miss, and never after fewer misses.
- R3: A burst requests the lines trigger_line + n*stride for n = 1 up to DEPTH (default 4), in that order. It needs no further misses to do so.
- R4: No request targets a line outside the 4 KB page of the triggering miss. The burst ends at the first line that would leave that page.
- R5: A miss whose stride differs from the current run restarts training. The last two misses become the new candidate stride, with a run of two.
- R6: A miss with the same set index as the previous miss never trains. It restarts the run count at one from that miss.
- R7: While pf_valid is high and pf_ready is low, pf_valid stays high and pf_line stays unchanged. When pf_ready is held high, one request is accepted per cycle.
- R8: While enable is low, pf_valid is low in the following cycle, any pending burst is dropped, training is cleared and misses are ignored.
- R9: After reset, pf_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low clears all state |
| run_len | input | 4 | Number of equally spaced misses needed to trigger |
| miss_valid | input | 1 | A demand miss is present this cycle |
| miss_addr | input | 32 | Physical address of the miss |
| pf_ready | input | 1 | Fill path accepts the offered request |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_line | output | 26 | Line address of the offered request |

## Verification
The first request of a burst is due in the cycle right after the edge that captures the k-th miss. The bench samples pf_valid and pf_line one time unit after the falling edge that follows that capture edge. With pf_ready high, each later line is due one cycle after the previous one was accepted. A scoreboard queue holds the expected lines and pops one only on a cycle where valid and ready are both seen. A request that arrives early, late, out of order or when none is expected therefore shows up as a mismatch or as an unexpected item. Lines that are missing are caught by a queue-empty check made a fixed number of cycles after each burst. The page clamp, disable and zero-stride cases are checked by sampling pf_valid at those same points.

// File: rtl/pf_pkg.sv
package pf_pkg;
    // Training phase of the stride detector.
    typedef enum logic [1:0] {
        PH_EMPTY = 2'd0,
        PH_ONE   = 2'd1,
        PH_RUN   = 2'd2
    } pf_phase_e;
endpackage

// File: rtl/pf_trainer.sv
module pf_trainer
    import pf_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int IDX_W  = 7,
    parameter int CNT_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     miss_valid,
    input  logic [LINE_W-1:0]        miss_line,
    input  logic [CNT_W-1:0]         run_len,
    output logic                     trig,
    output logic [LINE_W-1:0]        trig_line,
    output logic signed [IDX_W-1:0]  trig_stride
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        pf_phase_e               phase;
        logic [IDX_W-1:0]        prev_idx;
        logic signed [IDX_W-1:0] stride;
        logic [CNT_W-1:0]        cnt;
    } tr_state_t;

    tr_state_t st_d, st_q;

    logic [IDX_W-1:0]        idx;
    logic signed [IDX_W-1:0] delta;
    logic [CNT_W-1:0]        k_eff;
    logic [CNT_W:0]          cnt_inc;
    logic                    hit;

    always_comb begin
        idx     = miss_line[IDX_W-1:0];
        delta   = signed'(idx - st_q.prev_idx);
        k_eff   = (run_len < CNT_W'(2)) ? CNT_W'(2) : run_len;
        cnt_inc = {1'b0, st_q.cnt} + (CNT_W+1)'(1);
        hit     = 1'b0;
        st_d    = st_q;

        if (!enable) begin
            st_d = '{phase: PH_EMPTY, prev_idx: '0, stride: '0, cnt: '0};
        end else if (miss_valid) begin
            st_d.prev_idx = idx;
            case (st_q.phase)
                PH_EMPTY: begin
                    st_d.phase = PH_ONE;
                    st_d.cnt   = CNT_W'(1);
                end
                PH_ONE: begin
                    if (delta != '0) begin
                        st_d.phase  = PH_RUN;
                        st_d.stride = delta;
                        st_d.cnt    = CNT_W'(2);
                        hit         = (k_eff == CNT_W'(2));
                    end
                end
                default: begin
                    if (delta == '0) begin
                        st_d.phase  = PH_ONE;
                        st_d.stride = '0;
                        st_d.cnt    = CNT_W'(1);
                    end else if (delta == st_q.stride) begin
                        st_d.cnt = cnt_inc[CNT_W] ? CNT_MAX : cnt_inc[CNT_W-1:0];
                        hit      = (cnt_inc == {1'b0, k_eff});
                    end else begin
                        st_d.stride = delta;
                        st_d.cnt    = CNT_W'(2);
                        hit         = (k_eff == CNT_W'(2));
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_EMPTY, prev_idx: '0, stride: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign trig        = hit;
    assign trig_line   = miss_line;
    assign trig_stride = delta;

    // R6: a running stride is never zero
    p_stride_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |-> (st_q.stride != '0));

    // R2: a trigger only comes from an accepted miss with a nonzero stride
    p_trig_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (enable && miss_valid && trig_stride != '0));
endmodule

// File: rtl/pf_issuer.sv
module pf_issuer #(
    parameter int LINE_W = 26,
    parameter int IDX_W  = 7,
    parameter int PL_W   = 6,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     trig,
    input  logic [LINE_W-1:0]        trig_line,
    input  logic signed [IDX_W-1:0]  trig_stride,
    input  logic                     pf_ready,
    output logic                     pf_valid,
    output logic [LINE_W-1:0]        pf_line
);
    localparam int LEFT_W = (DEPTH < 2) ? 1 : $clog2(DEPTH + 1);
    localparam int PAGE_W = LINE_W - PL_W;

    typedef struct packed {
        logic                    valid;
        logic [LINE_W-1:0]       line;
        logic signed [IDX_W-1:0] stride;
        logic [LEFT_W-1:0]       left;
        logic [PAGE_W-1:0]       page;
    } is_state_t;

    is_state_t st_d, st_q;

    function automatic logic [LINE_W-1:0] step(input logic [LINE_W-1:0] l,
                                               input logic signed [IDX_W-1:0] s);
        return l + {{(LINE_W-IDX_W){s[IDX_W-1]}}, s};
    endfunction

    logic [LINE_W-1:0] nxt_run, nxt_new;

    always_comb begin
        nxt_run = step(st_q.line, st_q.stride);
        nxt_new = step(trig_line, trig_stride);
        st_d    = st_q;

        if (!enable) begin
            st_d = '0;
        end else if (st_q.valid) begin
            if (pf_ready) begin
                if (st_q.left != '0 && nxt_run[LINE_W-1:PL_W] == st_q.page) begin
                    st_d.line = nxt_run;
                    st_d.left = st_q.left - LEFT_W'(1);
                end else begin
                    st_d.valid = 1'b0;
                end
            end
        end else if (trig) begin
            st_d.page   = trig_line[LINE_W-1:PL_W];
            st_d.stride = trig_stride;
            st_d.line   = nxt_new;
            st_d.left   = LEFT_W'(DEPTH - 1);
            st_d.valid  = (nxt_new[LINE_W-1:PL_W] == trig_line[LINE_W-1:PL_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pf_valid = st_q.valid;
    assign pf_line  = st_q.line;

    // R7: an offered request is held until accepted
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && enable) |=> (pf_valid && $stable(pf_line)));

    // R4: every offered line lies in the trigger page
    p_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_line[LINE_W-1:PL_W] == st_q.page));

    // R8: disabling drops the burst
    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pf_valid);
endmodule

// File: rtl/stride_prefetch.sv
module stride_prefetch #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 7,
    parameter int PAGE_BITS = 12,
    parameter int CNT_W  = 4,
    parameter int DEPTH  = 4,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  run_len,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line
);
    localparam int PL_W = PAGE_BITS - OFF_W;

    logic                    trig;
    logic [LINE_W-1:0]       trig_line;
    logic signed [IDX_W-1:0] trig_stride;
    logic                    unused_off;

    assign unused_off = ^miss_addr[OFF_W-1:0];

    pf_trainer #(
        .LINE_W(LINE_W),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) trainer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .miss_valid (miss_valid),
        .miss_line  (miss_addr[ADDR_W-1:OFF_W]),
        .run_len    (run_len),
        .trig       (trig),
        .trig_line  (trig_line),
        .trig_stride(trig_stride)
    );

    pf_issuer #(
        .LINE_W(LINE_W),
        .IDX_W (IDX_W),
        .PL_W  (PL_W),
        .DEPTH (DEPTH)
    ) issuer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .trig       (trig),
        .trig_line  (trig_line),
        .trig_stride(trig_stride),
        .pf_ready   (pf_ready),
        .pf_valid   (pf_valid),
        .pf_line    (pf_line)
    );
endmodule

// File: tb/stride_prefetch_tb_top.sv
`timescale 1ns/1ps
module stride_prefetch_tb_top;
    localparam int LW = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [3:0]    run_len = 4'd3;
    logic          miss_valid = 1'b0;
    logic [31:0]   miss_addr = '0;
    logic          pf_ready = 1'b1;
    logic          pf_valid;
    logic [LW-1:0] pf_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [LW-1:0] exp_q[$];

    always #2 clk = ~clk;

    stride_prefetch dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run_len(run_len),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .pf_ready(pf_ready),
        .pf_valid(pf_valid), .pf_line(pf_line)
    );

    function automatic logic [LW-1:0] ln(input int n);
        return LW'(26'h400 + n);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic miss(input int n);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = {ln(n), 6'h15};
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic expect_lines(input int first, input int stride, input int cnt);
        for (int i = 0; i < cnt; i++) exp_q.push_back(ln(first + i * stride));
    endtask

    task automatic drained(input string req);
        idle(20);
        #1;
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        chk(pf_valid == 1'b0, req, pf_valid, 0);
    endtask

    task automatic clear_train;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
    endtask

    // Monitor: pops the scoreboard on every accepted request
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && pf_valid && pf_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected request", pf_line, 0);
                end else begin
                    logic [LW-1:0] e;
                    e = exp_q.pop_front();
                    chk(pf_line == e, "R3 request line", pf_line, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        #1;
        chk(pf_valid == 1'b0, "R9 reset state", pf_valid, 0);
        @(negedge clk);
        rst_n  = 1'b1;
        enable = 1'b1;

        // R2 R3 R1: stride of 2 lines, k=3
        run_len = 4'd3;
        expect_lines(6, 2, 4);
        miss(0);
        miss(2);
        #1 chk(pf_valid == 1'b0, "R2 no trigger after two misses", pf_valid, 0);
        miss(4);
        #1 chk(pf_valid == 1'b1, "R2 first request due", pf_valid, 1);
        drained("R3 burst of DEPTH lines");
        clear_train();

        // R4: page clamp, only line 62 is in page
        expect_lines(62, 2, 1);
        miss(56);
        miss(58);
        miss(60);
        drained("R4 page clamp");
        clear_train();

        // R2: negative stride of 3
        expect_lines(11, -3, 4);
        miss(20);
        miss(17);
        miss(14);
        drained("R2 negative stride");
        clear_train();

        // R5: broken stride restarts from last two misses
        expect_lines(11, 3, 4);
        miss(0);
        miss(2);
        miss(5);
        #1 chk(pf_valid == 1'b0, "R5 break does not trigger", pf_valid, 0);
        miss(8);
        drained("R5 restart stride");
        clear_train();

        // R6: zero stride never trains, restart count at one
        miss(30);
        miss(30);
        miss(30);
        miss(30);
        #1 chk(pf_valid == 1'b0, "R6 zero stride idle", pf_valid, 0);
        expect_lines(36, 2, 4);
        miss(32);
        #1 chk(pf_valid == 1'b0, "R6 count restarted at one", pf_valid, 0);
        miss(34);
        drained("R6 run after zero stride");
        clear_train();

        // R2: run_len below 2 acts as 2
        run_len = 4'd1;
        expect_lines(42, 1, 4);
        miss(40);
        miss(41);
        #1 chk(pf_valid == 1'b1, "R2 short run length", pf_valid, 1);
        drained("R2 short run burst");
        clear_train();
        run_len = 4'd3;

        // R7: backpressure holds the request
        pf_ready = 1'b0;
        expect_lines(12, 4, 4);
        miss(0);
        miss(4);
        miss(8);
        #1 chk(pf_valid == 1'b1, "R7 valid offered", pf_valid, 1);
        chk(pf_line == ln(12), "R7 first line", pf_line, ln(12));
        idle(3);
        #1 chk(pf_valid == 1'b1, "R7 valid held", pf_valid, 1);
        chk(pf_line == ln(12), "R7 line held", pf_line, ln(12));
        @(negedge clk);
        pf_ready = 1'b1;
        drained("R7 drained after ready");
        clear_train();

        // R8: disable drops a pending burst
        pf_ready = 1'b0;
        miss(0);
        miss(1);
        miss(2);
        #1 chk(pf_valid == 1'b1, "R8 burst pending", pf_valid, 1);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        #1 chk(pf_valid == 1'b0, "R8 dropped on disable", pf_valid, 0);
        enable   = 1'b1;
        pf_ready = 1'b1;
        drained("R8 no request after disable");

        // R8: misses ignored while disabled
        @(negedge clk);
        enable = 1'b0;
        miss(0);
        miss(2);
        miss(4);
        enable = 1'b1;
        drained("R8 misses ignored while disabled");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule